// File: doc/BRIEF.md
# Oversampling Decimation Accumulator

This block raises the effective resolution of a 12-bit converter by summing a group of consecutive conversion results and scaling the sum down to a wider output word. A pulse from a sampling timer opens each group. The block then counts qualified samples until the group is complete. One clock later it presents the result with a single-cycle valid strobe. Every sample carries the same weight, so the arithmetic is a boxcar FIR over one group followed by decimation.

Two modes are offered. In noise mode the group holds 4^p samples and the sum is shifted right by p, giving p extra bits from random input noise. In dither mode the input is assumed to be summed with a triangular ramp through an inverting stage. The group holds 2·2^p samples, the sum is halved, and a configured offset is removed to undo the inversion. The requested extra-bit count p, the mode and the offset are captured when a group opens. If a timer pulse arrives while a group is still collecting, the block raises a sticky overrun flag.

Top module: `osd_decimator`

## Requirements
- R1: While reset is held and after its release, res_valid_o, res_data_o and overrun_o are all 0.
- R2: With mode_i = 0 (noise), a group takes 4^p qualified samples, and the result is the sum of those samples shifted right by p. Example: 1250 constant gives 2500 for p = 1 and 5000 for p = 2.
- R3: With mode_i = 1 (dither), a group takes 2·2^p qualified samples, and the result is the sum shifted right by 1 minus offset_i. It is clamped to 0 when the offset exceeds the halved sum.
- R4: A sample is taken only when smp_valid_i is high and a group is open. Samples while idle, and the sample presented in the same cycle as an accepted start pulse, are ignored.
- R5: res_valid_o is high for exactly one clock, in the cycle after the clock edge that takes the final sample of a group, and is low otherwise.
- R6: A start pulse while a group is open sets overrun_o, which then stays set until reset. The pulse does not disturb the open group's count, sum or result.
- R7: An extra_bits_i value above 4 is treated as 4.
- R8: p, mode and offset are captured on the accepted start pulse. Later changes on those inputs do not affect the open group.
- R9: The accumulator cannot overflow. In noise mode with p = 4, 256 samples of 4095 produce 65520.
- R10: A start pulse in the same cycle that res_valid_o is high is accepted as a new group, without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Sampling-timer pulse that opens a group |
| smp_valid_i | input | 1 | Conversion result strobe |
| smp_data_i | input | 12 | Conversion result |
| extra_bits_i | input | 3 | Extra resolution bits p (values above 4 clamp to 4) |
| mode_i | input | 1 | 0 = noise averaging, 1 = triangular dither |
| offset_i | input | 16 | Offset removed from the result in dither mode |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 16 | Decimated result |
| overrun_o | output | 1 | Sticky flag: start pulse arrived while a group was open |

## Verification
The assertions assume the timer never needs a pulse dropped silently. They also assume that once a group is open, samples keep arriving until it completes, so the count bound and the end-of-group strobe are meaningful. The only input they watch directly is the start pulse. The stimulus keeps every table vector inside one group per start pulse. It drops the valid strobe on some cycles so that stalls are exercised. It raises a second start only in the two directed cases: during a group (overrun) and in the result cycle (back-to-back). In every start cycle it also drives a valid 4000 that the block must ignore.

// File: rtl/osd_pkg.sv
package osd_pkg;

  typedef enum logic {
    OSD_NOISE  = 1'b0,
    OSD_DITHER = 1'b1
  } osd_mode_e;

  // Number of samples per group for a mode and a clamped p.
  function automatic int unsigned osd_grp_len(osd_mode_e m, int unsigned p);
    if (m == OSD_DITHER) return 32'd2 << p;
    return 32'd1 << (2 * p);
  endfunction

  // Decimation scaling of a completed group sum.
  function automatic logic [31:0] osd_scale(osd_mode_e m, logic [31:0] sum,
                                            int unsigned p, logic [31:0] off);
    logic [31:0] half;
    if (m == OSD_NOISE) return sum >> p;
    half = sum >> 1;
    if (half < off) return 32'd0;
    return half - off;
  endfunction

endpackage

// File: rtl/osd_ctrl.sv
module osd_ctrl
  import osd_pkg::*;
#(
  parameter int P_MAX  = 4,
  parameter int P_IN_W = 3,
  parameter int OUT_W  = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              smp_valid_i,
  input  logic [P_IN_W-1:0] p_i,
  input  osd_mode_e         mode_i,
  input  logic [OUT_W-1:0]  off_i,
  output logic              busy_o,
  output logic              launch_o,
  output logic              ovr_hit_o,
  output logic              take_o,
  output logic              last_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  len_m1_o,
  output logic [P_IN_W-1:0] p_q_o,
  output osd_mode_e         mode_q_o,
  output logic [OUT_W-1:0]  off_q_o,
  output logic              overrun_o
);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  len_m1_q;
  logic [P_IN_W-1:0] p_q;
  osd_mode_e         mode_q;
  logic [OUT_W-1:0]  off_q;
  logic              ovr_q;

  logic [P_IN_W-1:0] p_eff;
  logic [CNT_W-1:0]  len_m1_d;

  assign p_eff    = (p_i > P_IN_W'(P_MAX)) ? P_IN_W'(P_MAX) : p_i;
  assign len_m1_d = CNT_W'(osd_grp_len(mode_i, 32'(p_eff)) - 32'd1);

  assign launch_o  = start_i & ~busy_q;
  assign ovr_hit_o = start_i & busy_q;
  assign take_o    = busy_q & smp_valid_i;
  assign last_o    = take_o & (cnt_q == len_m1_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      len_m1_q <= '0;
      p_q      <= '0;
      mode_q   <= OSD_NOISE;
      off_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (launch_o) begin
        busy_q   <= 1'b1;
        cnt_q    <= '0;
        len_m1_q <= len_m1_d;
        p_q      <= p_eff;
        mode_q   <= mode_i;
        off_q    <= off_i;
      end else begin
        if (last_o) busy_q <= 1'b0;
        if (take_o && !last_o) cnt_q <= cnt_q + 1'b1;
      end
      if (ovr_hit_o) ovr_q <= 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign cnt_o     = cnt_q;
  assign len_m1_o  = len_m1_q;
  assign p_q_o     = p_q;
  assign mode_q_o  = mode_q;
  assign off_q_o   = off_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/osd_accum.sv
module osd_accum #(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ACC_W-1:0]  sum_next_o
);

  logic [ACC_W-1:0] acc_q;

  assign sum_next_o = acc_q + ACC_W'(data_i);

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (take_i)  acc_q <= sum_next_o;
  end

endmodule

// File: rtl/osd_outreg.sv
module osd_outreg
  import osd_pkg::*;
#(
  parameter int ACC_W  = 20,
  parameter int OUT_W  = 16,
  parameter int P_IN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [ACC_W-1:0]  sum_i,
  input  osd_mode_e         mode_i,
  input  logic [P_IN_W-1:0] p_i,
  input  logic [OUT_W-1:0]  off_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  data_o
);

  logic [OUT_W-1:0] scaled;

  assign scaled = OUT_W'(osd_scale(mode_i, 32'(sum_i), 32'(p_i), 32'(off_i)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) data_o <= scaled;
    end
  end

endmodule

// File: rtl/osd_decimator.sv
module osd_decimator
  import osd_pkg::*;
#(
  parameter  int DATA_W = 12,
  parameter  int P_MAX  = 4,
  parameter  int P_IN_W = 3,
  localparam int OUT_W  = DATA_W + P_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic [P_IN_W-1:0] extra_bits_i,
  input  logic              mode_i,
  input  logic [OUT_W-1:0]  offset_i,
  output logic              res_valid_o,
  output logic [OUT_W-1:0]  res_data_o,
  output logic              overrun_o
);

  localparam int ACC_W = DATA_W + 2 * P_MAX;
  localparam int CNT_W = 2 * P_MAX + 2;

  // Named internal events, visible to the bound checker.
  logic              busy_w;
  logic              launch_w;
  logic              ovr_hit_w;
  logic              take_w;
  logic              last_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]  len_m1_w;
  logic [P_IN_W-1:0] p_q_w;
  osd_mode_e         mode_q_w;
  logic [OUT_W-1:0]  off_q_w;
  logic [ACC_W-1:0]  sum_next_w;

  osd_ctrl #(
    .P_MAX (P_MAX),
    .P_IN_W(P_IN_W),
    .OUT_W (OUT_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .smp_valid_i(smp_valid_i),
    .p_i        (extra_bits_i),
    .mode_i     (osd_mode_e'(mode_i)),
    .off_i      (offset_i),
    .busy_o     (busy_w),
    .launch_o   (launch_w),
    .ovr_hit_o  (ovr_hit_w),
    .take_o     (take_w),
    .last_o     (last_w),
    .cnt_o      (cnt_w),
    .len_m1_o   (len_m1_w),
    .p_q_o      (p_q_w),
    .mode_q_o   (mode_q_w),
    .off_q_o    (off_q_w),
    .overrun_o  (overrun_o)
  );

  osd_accum #(
    .DATA_W(DATA_W),
    .ACC_W (ACC_W)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (launch_w),
    .take_i    (take_w),
    .data_i    (smp_data_i),
    .sum_next_o(sum_next_w)
  );

  osd_outreg #(
    .ACC_W (ACC_W),
    .OUT_W (OUT_W),
    .P_IN_W(P_IN_W)
  ) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (last_w),
    .sum_i  (sum_next_w),
    .mode_i (mode_q_w),
    .p_i    (p_q_w),
    .off_i  (off_q_w),
    .valid_o(res_valid_o),
    .data_o (res_data_o)
  );

endmodule

// File: rtl/osd_decimator_chk.sv
module osd_decimator_chk
  import osd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int P_MAX  = 4,
  parameter int P_IN_W = 3,
  parameter int OUT_W  = 16,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy,
  input logic              take,
  input logic              last,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  len_m1,
  input logic [P_IN_W-1:0] p_q,
  input osd_mode_e         mode_q,
  input logic              res_valid,
  input logic [OUT_W-1:0]  res_data,
  input logic              overrun
);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r5_valid_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> res_valid);

  a_r5_valid_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(last));

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(start_i && busy));

  a_r6_count_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy && !take) |=> $stable(cnt));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= len_m1));

  a_r7_p_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(p_q) <= P_MAX));

  a_r2_noise_range: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode_q == OSD_NOISE) |->
      (32'(res_data) < (32'd1 << (DATA_W + 32'(p_q)))));

  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(p_q) && $stable(mode_q)));

endmodule

bind osd_decimator osd_decimator_chk #(
  .DATA_W(DATA_W),
  .P_MAX (P_MAX),
  .P_IN_W(P_IN_W),
  .OUT_W (OUT_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy     (busy_w),
  .take     (take_w),
  .last     (last_w),
  .cnt      (cnt_w),
  .len_m1   (len_m1_w),
  .p_q      (p_q_w),
  .mode_q   (mode_q_w),
  .res_valid(res_valid_o),
  .res_data (res_data_o),
  .overrun  (overrun_o)
);

// File: tb/osd_decimator_bench.sv
module osd_decimator_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] data = '0;
  logic [2:0]  pbits = '0;
  logic        mode = 1'b0;
  logic [15:0] offset = '0;
  logic        res_valid;
  logic [15:0] res_data;
  logic        overrun;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  osd_decimator u_osd_decimator (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .smp_valid_i (valid),
    .smp_data_i  (data),
    .extra_bits_i(pbits),
    .mode_i      (mode),
    .offset_i    (offset),
    .res_valid_o (res_valid),
    .res_data_o  (res_data),
    .overrun_o   (overrun)
  );

  typedef struct packed {
    logic        m;
    logic [2:0]  p;
    logic [15:0] off;
    logic [11:0] lo;
    logic [11:0] hi;
    logic [15:0] exp;
  } vec_t;

  // Samples alternate lo, hi, lo, hi ... ; expected values worked by hand.
  localparam vec_t VECS [12] = '{
    '{1'b0, 3'd0, 16'd0,    12'd1250, 12'd1250, 16'd1250},
    '{1'b0, 3'd1, 16'd0,    12'd1250, 12'd1250, 16'd2500},
    '{1'b0, 3'd2, 16'd0,    12'd1250, 12'd1250, 16'd5000},
    '{1'b0, 3'd1, 16'd0,    12'd100,  12'd101,  16'd201},
    '{1'b0, 3'd2, 16'd0,    12'd100,  12'd101,  16'd402},
    '{1'b0, 3'd4, 16'd0,    12'd4095, 12'd4095, 16'd65520},
    '{1'b1, 3'd3, 16'd0,    12'd1250, 12'd1250, 16'd10000},
    '{1'b1, 3'd0, 16'd0,    12'd7,    12'd8,    16'd7},
    '{1'b1, 3'd2, 16'd100,  12'd6,    12'd7,    16'd0},
    '{1'b1, 3'd2, 16'd20,   12'd6,    12'd7,    16'd6},
    '{1'b1, 3'd4, 16'd1000, 12'd4095, 12'd0,    16'd31760},
    '{1'b0, 3'd7, 16'd0,    12'd10,   12'd10,   16'd160}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_group(input logic m, input logic [2:0] p, input logic [15:0] off,
                           input logic [11:0] lo, input logic [11:0] hi,
                           input logic [15:0] exp, input bit gap, input string req);
    int unsigned pe;
    int unsigned len;
    pe  = (p > 3'd4) ? 4 : int'(p);
    len = m ? (2 ** (pe + 1)) : (4 ** pe);
    // Start cycle also carries a valid 4000 that must be ignored (R4).
    start = 1'b1; mode = m; pbits = p; offset = off; valid = 1'b1; data = 12'd4000;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < int'(len); i++) begin
      if (gap && (i % 3 == 2)) begin
        valid = 1'b0;
        @(negedge clk);
      end
      valid = 1'b1;
      data  = (i % 2 == 1) ? hi : lo;
      @(negedge clk);
    end
    valid = 1'b0; data = '0;
    check(res_valid === 1'b1, "R5", "valid after last sample", res_valid, 1);
    check(res_data == exp, req, "result", res_data, exp);
    @(negedge clk);
    check(res_valid === 1'b0, "R5", "valid one cycle only", res_valid, 0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    check(res_valid === 1'b0, "R1", "valid in reset", res_valid, 0);
    check(res_data == 16'd0, "R1", "data in reset", res_data, 0);
    check(overrun === 1'b0, "R1", "overrun in reset", overrun, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid === 1'b0 && overrun === 1'b0, "R1", "outputs after reset",
          {res_valid, overrun}, 0);

    // Table of vectors (R2, R3, R7, R9).
    for (int v = 0; v < 12; v++) begin
      if (VECS[v].p > 3'd4)          tag = "R7";
      else if (VECS[v].lo == 12'd4095 && !VECS[v].m) tag = "R9";
      else if (VECS[v].m)            tag = "R3";
      else                           tag = "R2";
      run_group(VECS[v].m, VECS[v].p, VECS[v].off, VECS[v].lo, VECS[v].hi,
                VECS[v].exp, (v % 2 == 1), tag);
    end
    check(overrun === 1'b0, "R6", "no overrun after clean groups", overrun, 0);

    // R8: configuration changes during a group have no effect.
    start = 1'b1; mode = 1'b0; pbits = 3'd1; offset = 16'd0; valid = 1'b0;
    @(negedge clk);
    start = 1'b0; mode = 1'b1; pbits = 3'd4; offset = 16'd50;
    for (int i = 0; i < 4; i++) begin
      valid = 1'b1; data = 12'd100;
      @(negedge clk);
    end
    valid = 1'b0;
    check(res_valid === 1'b1 && res_data == 16'd200, "R8", "result with held config",
          res_data, 200);
    @(negedge clk);

    // R4: samples while idle are ignored.
    mode = 1'b0; pbits = 3'd0; offset = 16'd0;
    for (int i = 0; i < 3; i++) begin
      valid = 1'b1; data = 12'd4095;
      @(negedge clk);
      check(res_valid === 1'b0, "R4", "no result from idle sample", res_valid, 0);
    end
    valid = 1'b0;
    run_group(1'b0, 3'd0, 16'd0, 12'd77, 12'd77, 16'd77, 1'b0, "R4");

    // R10: start accepted in the result cycle.
    start = 1'b1; mode = 1'b0; pbits = 3'd0;
    @(negedge clk);
    start = 1'b0; valid = 1'b1; data = 12'd5;
    @(negedge clk);
    check(res_valid === 1'b1 && res_data == 16'd5, "R10", "first group", res_data, 5);
    start = 1'b1; valid = 1'b0;
    @(negedge clk);
    start = 1'b0; valid = 1'b1; data = 12'd9;
    @(negedge clk);
    valid = 1'b0;
    check(res_valid === 1'b1 && res_data == 16'd9, "R10", "back-to-back group",
          res_data, 9);
    check(overrun === 1'b0, "R10", "no overrun on back-to-back", overrun, 0);
    @(negedge clk);

    // R6: start during an open group.
    start = 1'b1; mode = 1'b0; pbits = 3'd1;
    @(negedge clk);
    start = 1'b0; valid = 1'b1; data = 12'd20;
    @(negedge clk);
    start = 1'b1; data = 12'd20;
    @(negedge clk);
    start = 1'b0;
    check(overrun === 1'b1, "R6", "overrun set", overrun, 1);
    check(res_valid === 1'b0, "R6", "no early result", res_valid, 0);
    data = 12'd20;
    @(negedge clk);
    data = 12'd20;
    @(negedge clk);
    valid = 1'b0;
    check(res_valid === 1'b1 && res_data == 16'd40, "R6", "group undisturbed",
          res_data, 40);
    @(negedge clk);
    run_group(1'b0, 3'd0, 16'd0, 12'd3, 12'd3, 16'd3, 1'b0, "R2");
    check(overrun === 1'b1, "R6", "overrun sticky", overrun, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule